// File: doc/BRIEF.md
# Cascaded Quad-DAC Serial Update Sequencer

This controller sits on the host side of a chain of quad 12-bit serial DACs. Each device holds a 48-bit shift path of four 12-bit channels, and the devices are cascaded, so one long frame reaches every channel in the chain. The host presents one request carrying every code in the chain and a four-bit channel mask. The controller lowers chip select and shifts the frame out on a divided serial clock. It then waits a fixed gap and pulses the active-low update strobes of the channels in the mask. The same channel strobe is shared by all devices in the chain. With every mask bit set, all channels update at once. With a single bit set, only that channel updates.

The serial clock idles high. The device samples data on the falling edge, so the controller changes data only on rising edges, and the data stays stable for a full low phase. A separate clear request drives an active-low clear pulse of programmed width. No transfer can start while that pulse is in progress. The host sees a busy level and a one-cycle done pulse.

Top module: `qdac_chain_ctrl`

## Requirements
- R1: After reset, sclk, cs_n, clr_n and all four upd_n lines are high, and busy and done are low.
- R2: One transfer shifts exactly 48*NUM_DEV bits. The codes bus holds channel c (0 = A … 3 = D) of device d at bits [(d*4+c)*12 +: 12], MSB at the high end. The bus is sent from its top bit down to bit 0, so device NUM_DEV-1 channel D bit 11 goes first and device 0 channel A bit 0 goes last.
- R3: sclk idles high. Every low phase and every high phase between falling edges lasts exactly HALF_DIV system cycles. sdata never changes while sclk is low.
- R4: cs_n falls HALF_DIV cycles before the first falling sclk edge. It stays low until HALF_DIV cycles after the strobe ends, and sclk is never low while cs_n is high.
- R5: The strobe starts exactly 2*HALF_DIV+GAP_TICKS cycles after the last falling sclk edge and lasts exactly STROBE_TICKS cycles.
- R6: upd_n[c] pulses low exactly when mask bit c was set at request time, and all selected lines move together. A zero mask produces no strobe, but the rest of the timing is unchanged.
- R7: busy is high from the cycle after acceptance until the transfer ends. done is high for exactly one cycle, in the cycle in which cs_n returns high.
- R8: A request that arrives while busy is ignored: the frame, the strobe mask and the single done are those of the first request.
- R9: A clear request while idle drives clr_n low for exactly CLR_TICKS cycles with busy high and no done. A clear request wins over a data request in the same cycle, and a data request during the pulse is ignored.
- R10: A data request made after the clear pulse has ended is accepted and performed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start a data transfer (one cycle, sampled when idle) |
| ch_mask | input | 4 | Channels to update; bit 0 = channel A |
| codes | input | 48*NUM_DEV | All channel codes of the chain |
| clr_req | input | 1 | Start a clear pulse (sampled when idle) |
| busy | output | 1 | Transfer or clear in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data toward the first device |
| cs_n | output | 1 | Active-low chip select |
| upd_n | output | 4 | Active-low per-channel update strobes |
| clr_n | output | 1 | Active-low clear pulse |

## Verification
The bench rebuilds each frame from the falling sclk edges and compares it with the bit order computed from the codes bus. A reversed channel or device order, or data that changes on the wrong edge, would show up as mismatched bits. It measures the gap from the last falling edge to the strobe, the strobe width and the cs_n hold in system cycles. A controller that strobes too early, or releases chip select while the strobe is still active, fails those distances. It also targets the mask corners (zero, single bit, all bits), a request injected in the middle of a transfer, and a request made during or together with a clear. A controller that restarts, merges masks or lets a transfer overlap the clear pulse would produce an extra done, a corrupted frame or a chip-select edge inside the clear pulse.

// File: rtl/qdac_pkg.sv
// Shared types for the cascaded quad-DAC update sequencer.
package qdac_pkg;
    localparam int CH_PER_DEV = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_STROBE,
        ST_HOLD,
        ST_CLEAR
    } seq_state_t;
endpackage

// File: rtl/qdac_timer.sv
// Phase timer: loads a duration minus one and counts down to zero.
// Assumes the caller reloads it on every state entry; expired marks the last cycle of a phase.
module qdac_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Count down from the loaded value and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/qdac_shiftout.sv
// MSB-first parallel-load shift register that feeds the serial data pin.
// Assumes load and shift are never requested in the same cycle.
module qdac_shiftout #(
    parameter int WIDTH = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             shift,
    output logic             msb
);
    logic [WIDTH-1:0] sreg;

    // Capture the frame on load and move it one place toward the MSB on shift.
    always_ff @(posedge clk) begin
        if (!rst_n)     sreg <= '0;
        else if (load)  sreg <= load_data;
        else if (shift) sreg <= {sreg[WIDTH-2:0], 1'b0};
    end

    assign msb = sreg[WIDTH-1];
endmodule

// File: rtl/qdac_chain_ctrl.sv
// Sequencer for a chain of NUM_DEV cascaded quad serial DACs.
// Shifts one 48*NUM_DEV-bit frame MSB first on a divided clock that idles high.
// Data changes on rising sclk edges. After a gap it strobes the masked channels, then releases chip select.
// Also produces an active-low clear pulse. Assumes all tick parameters are at least 1.
module qdac_chain_ctrl
    import qdac_pkg::*;
#(
    parameter int NUM_DEV      = 2,
    parameter int CODE_W       = 12,
    parameter int HALF_DIV     = 3,
    parameter int GAP_TICKS    = 4,
    parameter int STROBE_TICKS = 4,
    parameter int CLR_TICKS    = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req,
    input  logic [CH_PER_DEV-1:0]                ch_mask,
    input  logic [NUM_DEV*CH_PER_DEV*CODE_W-1:0] codes,
    input  logic                                 clr_req,
    output logic                                 busy,
    output logic                                 done,
    output logic                                 sclk,
    output logic                                 sdata,
    output logic                                 cs_n,
    output logic [CH_PER_DEV-1:0]                upd_n,
    output logic                                 clr_n
);
    localparam int FRAME_W = NUM_DEV * CH_PER_DEV * CODE_W;
    localparam int BIT_W   = $clog2(FRAME_W + 1);
    localparam int MAX_A   = (HALF_DIV > GAP_TICKS) ? HALF_DIV : GAP_TICKS;
    localparam int MAX_B   = (STROBE_TICKS > CLR_TICKS) ? STROBE_TICKS : CLR_TICKS;
    localparam int MAX_T   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W   = $clog2(MAX_T + 1);

    seq_state_t            state, state_n;
    logic                  tmr_load, tmr_exp, accept, do_shift;
    logic [TMR_W-1:0]      tmr_val;
    logic [BIT_W-1:0]      bitcnt;
    logic [CH_PER_DEV-1:0] mask_q;
    logic                  sclk_q, cs_n_q, clr_n_q, busy_q, done_q;
    logic [CH_PER_DEV-1:0] upd_n_q;

    qdac_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    qdac_shiftout #(.WIDTH(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_data(codes),
        .shift(do_shift), .msb(sdata)
    );

    // Next-state and phase timer reload decisions.
    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        do_shift = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (clr_req) begin
                    state_n = ST_CLEAR; tmr_load = 1'b1; tmr_val = TMR_W'(CLR_TICKS - 1);
                end else if (req) begin
                    state_n = ST_SETUP; tmr_load = 1'b1; tmr_val = TMR_W'(HALF_DIV - 1);
                    accept  = 1'b1;
                end
            end
            ST_SETUP: if (tmr_exp) begin
                state_n = ST_LOW; tmr_load = 1'b1; tmr_val = TMR_W'(HALF_DIV - 1);
            end
            ST_LOW: if (tmr_exp) begin
                state_n = ST_HIGH; tmr_load = 1'b1; tmr_val = TMR_W'(HALF_DIV - 1);
                do_shift = 1'b1;
            end
            ST_HIGH: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (bitcnt == BIT_W'(FRAME_W)) begin
                    state_n = ST_GAP; tmr_val = TMR_W'(GAP_TICKS - 1);
                end else begin
                    state_n = ST_LOW; tmr_val = TMR_W'(HALF_DIV - 1);
                end
            end
            ST_GAP: if (tmr_exp) begin
                state_n = ST_STROBE; tmr_load = 1'b1; tmr_val = TMR_W'(STROBE_TICKS - 1);
            end
            ST_STROBE: if (tmr_exp) begin
                state_n = ST_HOLD; tmr_load = 1'b1; tmr_val = TMR_W'(HALF_DIV - 1);
            end
            ST_HOLD:  if (tmr_exp) state_n = ST_IDLE;
            ST_CLEAR: if (tmr_exp) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // State, bit counter, captured mask and registered pin values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            mask_q  <= '0;
            sclk_q  <= 1'b1;
            cs_n_q  <= 1'b1;
            upd_n_q <= '1;
            clr_n_q <= 1'b1;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state <= state_n;
            if (accept) begin
                bitcnt <= '0;
                mask_q <= ch_mask;
            end else if (state == ST_LOW && tmr_exp) begin
                bitcnt <= bitcnt + 1'b1;
            end
            sclk_q  <= (state_n != ST_LOW);
            cs_n_q  <= (state_n == ST_IDLE) || (state_n == ST_CLEAR);
            upd_n_q <= (state_n == ST_STROBE) ? ~mask_q : '1;
            clr_n_q <= (state_n != ST_CLEAR);
            busy_q  <= (state_n != ST_IDLE);
            done_q  <= (state == ST_HOLD) && tmr_exp;
        end
    end

    assign sclk  = sclk_q;
    assign cs_n  = cs_n_q;
    assign upd_n = upd_n_q;
    assign clr_n = clr_n_q;
    assign busy  = busy_q;
    assign done  = done_q;

    // R4: the serial clock only runs under chip select.
    p_clk_under_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_q |-> !cs_n_q);
    // R3: data held for the whole low phase.
    p_data_stable_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_q && $past(!sclk_q)) |-> $stable(sdata));
    // R5: strobe only inside chip select with the clock parked high.
    p_strobe_framed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_n_q != '1) |-> (!cs_n_q && sclk_q));
    // R6: only masked channels strobe.
    p_strobe_in_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_n_q != '1) |-> ((~upd_n_q & ~mask_q) == '0));
    // R7: done is a single cycle and lands in idle.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_at_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && cs_n_q));
    // R9: no transfer overlaps the clear pulse.
    p_clear_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_q |-> (cs_n_q && busy_q));
    // R2: the bit counter never runs past the frame.
    p_bit_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= BIT_W'(FRAME_W));
endmodule

// File: tb/sim_qdac_chain_ctrl.sv
module sim_qdac_chain_ctrl;
    localparam int ND = 2, CW = 12, HALF = 2, GAP = 3, LW = 4, CLRW = 5;
    localparam int FW = ND * 4 * CW;

    logic clk = 0, rst_n = 0, req = 0, clr_req = 0;
    logic [3:0] ch_mask = '0;
    logic [FW-1:0] codes = '0;
    logic busy, done, sclk, sdata, cs_n, clr_n;
    logic [3:0] upd_n;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    qdac_chain_ctrl #(.NUM_DEV(ND), .CODE_W(CW), .HALF_DIV(HALF), .GAP_TICKS(GAP),
                      .STROBE_TICKS(LW), .CLR_TICKS(CLRW)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .ch_mask(ch_mask), .codes(codes),
        .clr_req(clr_req), .busy(busy), .done(done), .sclk(sclk), .sdata(sdata),
        .cs_n(cs_n), .upd_n(upd_n), .clr_n(clr_n));

    always #2 clk = ~clk;

    // monitor state
    logic cap [0:FW-1];
    int capn, first_fall, last_fall, last_rise, upd_fall, upd_rise;
    int cs_fall, cs_rise, done_cnt, done_cyc, clr_fall, clr_rise;
    int bad_phase, bad_data, bad_busy;
    logic [3:0] seen_mask;
    logic p_sclk = 1, p_sdata = 0, p_cs = 1, p_clr = 1;
    logic [3:0] p_upd = '1;

    task automatic reset_mon();
        capn = 0; first_fall = -1; last_fall = -1; last_rise = -1;
        upd_fall = -1; upd_rise = -1; cs_fall = -1; cs_rise = -1;
        done_cnt = 0; done_cyc = -1; clr_fall = -1; clr_rise = -1;
        bad_phase = 0; bad_data = 0; bad_busy = 0; seen_mask = '0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_sclk && !sclk) begin
                if (capn < FW) cap[capn] = sdata;
                if (capn == 0) first_fall = cyc;
                else if (cyc - last_rise != HALF) bad_phase++;
                capn++;
                last_fall = cyc;
            end
            if (!p_sclk && sclk) begin
                last_rise = cyc;
                if (cyc - last_fall != HALF) bad_phase++;
            end
            if (!p_sclk && !sclk && sdata !== p_sdata) bad_data++;
            if (p_upd == 4'hF && upd_n != 4'hF) upd_fall = cyc;
            if (p_upd != 4'hF && upd_n == 4'hF) upd_rise = cyc;
            if (upd_n != 4'hF && seen_mask != '0 && ~upd_n != seen_mask) bad_phase++;
            seen_mask |= ~upd_n;
            if (p_cs && !cs_n) cs_fall = cyc;
            if (!p_cs && cs_n) cs_rise = cyc;
            if (p_clr && !clr_n) clr_fall = cyc;
            if (!p_clr && clr_n) clr_rise = cyc;
            if (done) begin done_cnt++; done_cyc = cyc; end
            if ((!cs_n || !clr_n) && !busy) bad_busy++;
        end
        p_sclk = sclk; p_sdata = sdata; p_cs = cs_n; p_clr = clr_n; p_upd = upd_n;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [FW-1:0] c, input int k);
        return c[FW-1-k];
    endfunction

    function automatic logic [FW-1:0] rand_codes();
        logic [FW-1:0] v;
        for (int s = 0; s < ND * 4; s++) v[s*CW +: CW] = CW'($urandom & 32'hFFF);
        return v;
    endfunction

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done_cnt > 0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    // One transfer; intr > 0 injects a foreign request that many cycles after start (R8).
    task automatic run_xfer(input logic [FW-1:0] c, input logic [3:0] m, input int intr);
        int mism;
        reset_mon();
        @(posedge clk); #1;
        codes = c; ch_mask = m; req = 1;
        @(posedge clk); #1;
        req = 0;
        if (intr > 0) begin
            repeat (intr) @(posedge clk);
            #1; codes = ~c; ch_mask = ~m; req = 1;
            @(posedge clk); #1; req = 0;
        end
        wait_done();
        mism = 0;
        for (int k = 0; k < FW; k++) if (cap[k] !== exp_bit(c, k)) mism++;
        chk(capn == FW, "R2 bit count", capn, FW);
        chk(mism == 0, "R2 frame bits", mism, 0);
        chk(cap[0] === c[FW-1] && cap[FW-1] === c[0], "R2 first/last bit", int'(cap[0]), int'(c[FW-1]));
        chk(bad_phase == 0, "R3 phase widths", bad_phase, 0);
        chk(bad_data == 0, "R3 data stable low", bad_data, 0);
        chk(first_fall - cs_fall == HALF, "R4 cs setup", first_fall - cs_fall, HALF);
        if (m != 0) begin
            chk(upd_fall - last_fall == 2*HALF + GAP, "R5 strobe gap", upd_fall - last_fall, 2*HALF + GAP);
            chk(upd_rise - upd_fall == LW, "R5 strobe width", upd_rise - upd_fall, LW);
            chk(cs_rise - upd_rise == HALF, "R4 cs hold", cs_rise - upd_rise, HALF);
        end else begin
            chk(upd_fall == -1, "R6 no strobe for zero mask", upd_fall, -1);
            chk(cs_rise - last_fall == 3*HALF + GAP + LW, "R6 zero mask timing",
                cs_rise - last_fall, 3*HALF + GAP + LW);
        end
        chk(seen_mask == m, "R6 strobe mask", seen_mask, m);
        chk(done_cnt == 1, intr > 0 ? "R8 single done" : "R7 single done", done_cnt, 1);
        chk(done_cyc == cs_rise, "R7 done at cs release", done_cyc, cs_rise);
        chk(bad_busy == 0, "R7 busy covers transfer", bad_busy, 0);
    endtask

    // Clear pulse; with_req also raises req in the same cycle, and later during the pulse.
    task automatic run_clear(input bit with_req);
        reset_mon();
        @(posedge clk); #1;
        clr_req = 1; req = with_req; codes = rand_codes(); ch_mask = 4'hF;
        @(posedge clk); #1;
        clr_req = 0; req = 0;
        @(posedge clk); #1; req = 1;
        @(posedge clk); #1; req = 0;
        repeat (CLRW + 6) @(negedge clk);
        chk(clr_rise - clr_fall == CLRW, "R9 clear width", clr_rise - clr_fall, CLRW);
        chk(cs_fall == -1, "R9 no transfer in clear", cs_fall, -1);
        chk(done_cnt == 0, "R9 no done for clear", done_cnt, 0);
        chk(bad_busy == 0, "R9 busy during clear", bad_busy, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sclk && cs_n && clr_n && upd_n == 4'hF, "R1 pin idle", {sclk, cs_n, clr_n, upd_n}, 7'h7F);
        chk(!busy && !done, "R1 status idle", {busy, done}, 0);
        @(posedge clk); #1; rst_n = 1;
        repeat (2) @(posedge clk);
        // directed corners
        run_xfer({FW{1'b0}} | {1'b1, {(FW-2){1'b0}}, 1'b1}, 4'hF, 0);
        run_xfer({FW/2{2'b10}}, 4'h0, 0);
        run_xfer(rand_codes(), 4'h1, 0);
        run_xfer(rand_codes(), 4'h8, 0);
        run_xfer(rand_codes(), 4'h5, 37);
        run_clear(1'b0);
        run_clear(1'b1);
        run_xfer(rand_codes(), 4'hA, 0); // R10 accepted after clear
        // random
        for (int t = 0; t < 12; t++)
            run_xfer(rand_codes(), 4'($urandom), (t % 3 == 0) ? int'($urandom % 300) + 1 : 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule